// File: doc/BRIEF.md
# IR Sample Run-Length Encoder

This block converts a stream of packed infrared receiver samples into duration words. Each incoming byte holds eight consecutive sample bits. The block inverts each byte, so that a 1 bit marks carrier present (pulse) and a 0 bit marks silence (space). It then steps through the bits from the least significant bit upward, one bit per clock. Each bit adds a fixed bit period to the accumulator of its level. When the level changes, the finished duration of the previous level is written as a tagged word into a small output queue.

Bytes arrive in bursts. A start strobe carries the number of bytes that the sample buffer holds. The block accepts at most a fixed number of bytes per burst, and it sees only the bytes it accepts. When a burst is finished, the block checks the accumulated silence. If the silence is longer than the timeout, it raises a one-cycle re-arm request, so that the surrounding receiver logic can restart capture. The output queue never stalls sample processing. A word that finds the queue full is dropped.

Top module: `ir_rle_encoder`

## Requirements
- R1: After reset, outValid, inReady and rearmReq are 0. The previous level is space, and both the pulse and the space accumulators are 0.
- R2: Every accepted byte is bitwise inverted before use. After inversion, a 1 bit is pulse and a 0 bit is space. For example, input 0x00 is eight pulse bits.
- R3: The bits of an inverted byte are handled from bit 0 up to bit 7, one bit per clock. The first bit is handled in the cycle after the byte is accepted.
- R4: Each bit adds BIT_US (default 52) to the accumulator of its own level. Durations continue across byte and burst boundaries.
- R5: A pulse bit that follows space emits the space accumulator and clears it. A space bit that follows pulse emits the pulse accumulator and clears it. A pulse bit arriving first after reset therefore emits a space word of duration 0.
- R6: An output word carries the duration in bits [DUR_W-1:0] (default 24) and the pulse flag in bit DUR_W. The flag is 1 for pulse and 0 for space. All higher bits are 0.
- R7: An emitted duration larger than 2^DUR_W-1 is replaced by 2^DUR_W-1.
- R8: A burst start latches min(burstLen, MAX_BURST) (MAX_BURST default 32) as the number of bytes to take. inReady is high only while the block waits for the next byte of a burst. A burst length of 0 takes no byte.
- R9: At the end of a burst, rearmReq pulses high for exactly one cycle if the space accumulator exceeds TIMEOUT_US (default 100000). Otherwise it stays low.
- R10: A word emitted while the output queue is full is dropped. Sample processing and byte acceptance continue at full rate.
- R11: The output queue delivers words in emission order. While outValid is high and outReady is low, the word is held stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| burstGo | input | 1 | Start strobe for a burst, taken only while the block is idle |
| burstLen | input | CNT_W | Number of bytes reported for the burst |
| inByte | input | 8 | Packed sample byte |
| inValid | input | 1 | inByte is valid |
| inReady | output | 1 | Block accepts a byte in this cycle |
| outWord | output | WORD_W | Duration word at the head of the queue |
| outValid | output | 1 | outWord is valid |
| outReady | input | 1 | Consumer takes outWord |
| rearmReq | output | 1 | One-cycle request to re-arm the receiver after a long silence |

## Verification
Take a byte accepted at clock edge e. Bit k of that byte is handled at edge e+1+k. Any word caused by bit k shows on outValid right after that same edge. The next byte can be taken at edge e+9 at the earliest. If the byte is the last one of its burst, rearmReq is high only in the cycle after edge e+9.

The bench drives and samples on falling edges. It offers each byte and waits until it sees inReady high, so byte acceptance is observed directly rather than assumed. It gathers words as they leave the queue. It latches any rearmReq pulse in a sticky flag that is cleared when a burst starts. After each burst it waits twelve cycles, which covers every latency above, and then compares the flag and the gathered words with an arithmetic model of the requirements.

// File: rtl/ir_rle_pkg.sv
package ir_rle_pkg;

  // Strobes issued by the control FSM to the datapath, one cycle each.
  typedef struct packed {
    logic loadByte;  // capture inByte (handshake completes this cycle)
    logic shiftBit;  // consume one bit of the held byte
    logic burstEnd;  // burst is finished, evaluate silence timeout
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DONE  = 2'd3
  } ctrlState_t;

endpackage

// File: rtl/ir_rle_ctrl.sv
module ir_rle_ctrl
  import ir_rle_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int MAX_BURST = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             burstGo,
  input  logic [CNT_W-1:0] burstLen,
  input  logic             inValid,
  output logic             inReady,
  output ctrlStrobes_t     strb
);

  localparam int BURST_W = $clog2(MAX_BURST + 1);

  ctrlState_t         state, stateNext;
  logic [BURST_W-1:0] bytesLeft;
  logic [BURST_W-1:0] capLen;
  logic [2:0]         bitIdx;
  logic               lastBit;

  always_comb begin
    if (burstLen > CNT_W'(MAX_BURST)) capLen = BURST_W'(MAX_BURST);
    else                              capLen = BURST_W'(burstLen);
  end

  assign inReady = (state == ST_FETCH);
  assign lastBit = (bitIdx == 3'd7);

  always_comb begin
    strb.loadByte = (state == ST_FETCH) && inValid;
    strb.shiftBit = (state == ST_SHIFT);
    strb.burstEnd = (state == ST_DONE);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (burstGo) stateNext = (capLen == '0) ? ST_DONE : ST_FETCH;
      ST_FETCH: if (inValid) stateNext = ST_SHIFT;
      ST_SHIFT: if (lastBit) stateNext = (bytesLeft == BURST_W'(1)) ? ST_DONE : ST_FETCH;
      ST_DONE:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bytesLeft <= '0;
      bitIdx    <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE && burstGo) bytesLeft <= capLen;
      if (strb.loadByte) bitIdx <= '0;
      if (strb.shiftBit) begin
        bitIdx <= bitIdx + 3'd1;
        if (lastBit) bytesLeft <= bytesLeft - BURST_W'(1);
      end
    end
  end

  // ---- assertions ----
  logic [BURST_W:0] takenCnt;
  always_ff @(posedge clk) begin
    if (!rstN) takenCnt <= '0;
    else if (state == ST_IDLE && burstGo) takenCnt <= '0;
    else if (strb.loadByte) takenCnt <= takenCnt + 1'b1;
  end

  a_r8_burst_cap: assert property (@(posedge clk) disable iff (!rstN)
    takenCnt <= (BURST_W+1)'(MAX_BURST));

  a_r3_shift_follows_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadByte |=> strb.shiftBit);

  a_r8_ready_not_while_shifting: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftBit |-> !inReady);

endmodule

// File: rtl/ir_rle_datapath.sv
module ir_rle_datapath
  import ir_rle_pkg::*;
#(
  parameter int DUR_W      = 24,
  parameter int WORD_W     = 32,
  parameter int BIT_US     = 52,
  parameter int TIMEOUT_US = 100000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [7:0]        inByte,
  output logic              pushValid,
  output logic [WORD_W-1:0] pushWord,
  output logic              rearmReq
);

  localparam int ACC_W = 32;
  localparam logic [DUR_W-1:0] DUR_MAX = '1;
  localparam logic [ACC_W-1:0] DUR_MAX_ACC = ACC_W'(DUR_MAX);
  localparam logic [ACC_W-1:0] LIMIT = ACC_W'(TIMEOUT_US);

  logic [7:0]       shReg;
  logic             lastLevel;
  logic [ACC_W-1:0] accPulse, accSpace;
  logic             curBit;
  logic [ACC_W-1:0] pulseInc, spaceInc;
  logic [ACC_W-1:0] doneDur;
  logic [DUR_W-1:0] satDur;

  assign curBit = shReg[0];

  // Saturating add of one bit period.
  function automatic logic [ACC_W-1:0] addBit(input logic [ACC_W-1:0] a);
    logic [ACC_W:0] s;
    s = {1'b0, a} + (ACC_W+1)'(BIT_US);
    return s[ACC_W] ? '1 : s[ACC_W-1:0];
  endfunction

  assign pulseInc = addBit(accPulse);
  assign spaceInc = addBit(accSpace);

  always_comb begin
    doneDur   = lastLevel ? accPulse : accSpace;
    satDur    = (doneDur > DUR_MAX_ACC) ? DUR_MAX : doneDur[DUR_W-1:0];
    pushValid = strb.shiftBit && (curBit != lastLevel);
    pushWord        = '0;
    pushWord[DUR_W-1:0] = satDur;
    pushWord[DUR_W] = lastLevel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg     <= '0;
      lastLevel <= 1'b0;
      accPulse  <= '0;
      accSpace  <= '0;
      rearmReq  <= 1'b0;
    end else begin
      rearmReq <= strb.burstEnd && (accSpace > LIMIT);
      if (strb.loadByte) shReg <= ~inByte;
      if (strb.shiftBit) begin
        shReg     <= {1'b0, shReg[7:1]};
        lastLevel <= curBit;
        if (curBit) begin
          accPulse <= pulseInc;
          if (!lastLevel) accSpace <= '0;
        end else begin
          accSpace <= spaceInc;
          if (lastLevel) accPulse <= '0;
        end
      end
    end
  end

  // ---- assertions ----
  a_r9_rearm_single: assert property (@(posedge clk) disable iff (!rstN)
    rearmReq |=> !rearmReq);

  a_r5_space_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (strb.shiftBit && curBit && !lastLevel) |=> (accSpace == '0));

  a_r5_pulse_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (strb.shiftBit && !curBit && lastLevel) |=> (accPulse == '0));

  a_r4_pulse_grows: assert property (@(posedge clk) disable iff (!rstN)
    (strb.shiftBit && curBit && lastLevel) |=> (accPulse >= $past(accPulse)));

endmodule

// File: rtl/ir_rle_outq.sv
module ir_rle_outq #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic [WORD_W-1:0] pushWord,
  output logic [WORD_W-1:0] outWord,
  output logic              outValid,
  input  logic              outReady
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              doPush, doPop, full;

  assign full     = (count == CNT_W'(DEPTH));
  assign outValid = (count != '0);
  assign outWord  = mem[rdPtr];
  assign doPop    = outValid && outReady;
  assign doPush   = pushValid && !full;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= bump(wrPtr);
      if (doPop)  rdPtr <= bump(rdPtr);
      unique case ({doPush, doPop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  // ---- assertions ----
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (full && !doPop) |=> full);

  a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outWord)));

  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

endmodule

// File: rtl/ir_rle_encoder.sv
module ir_rle_encoder
  import ir_rle_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int MAX_BURST  = 32,
  parameter int DUR_W      = 24,
  parameter int WORD_W     = 32,
  parameter int BIT_US     = 52,
  parameter int TIMEOUT_US = 100000,
  parameter int OQ_DEPTH   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              burstGo,
  input  logic [CNT_W-1:0]  burstLen,
  input  logic [7:0]        inByte,
  input  logic              inValid,
  output logic              inReady,
  output logic [WORD_W-1:0] outWord,
  output logic              outValid,
  input  logic              outReady,
  output logic              rearmReq
);

  ctrlStrobes_t      strb;
  logic              pushValid;
  logic [WORD_W-1:0] pushWord;

  ir_rle_ctrl #(.CNT_W(CNT_W), .MAX_BURST(MAX_BURST)) u_ctrl (
    .clk(clk), .rstN(rstN), .burstGo(burstGo), .burstLen(burstLen),
    .inValid(inValid), .inReady(inReady), .strb(strb)
  );

  ir_rle_datapath #(.DUR_W(DUR_W), .WORD_W(WORD_W), .BIT_US(BIT_US),
                    .TIMEOUT_US(TIMEOUT_US)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inByte(inByte),
    .pushValid(pushValid), .pushWord(pushWord), .rearmReq(rearmReq)
  );

  ir_rle_outq #(.WORD_W(WORD_W), .DEPTH(OQ_DEPTH)) u_outq (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushWord(pushWord),
    .outWord(outWord), .outValid(outValid), .outReady(outReady)
  );

  a_r6_upper_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outWord >> (DUR_W + 1)) == '0);

endmodule

// File: tb/test_ir_rle_encoder.sv
module test_ir_rle_encoder;

  localparam int TB_DUR   = 10;
  localparam int TB_Q     = 4;
  localparam int TB_BIT   = 52;
  localparam int TB_LIMIT = 100000;
  localparam longint DMAX = (64'd1 << TB_DUR) - 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        burstGo = 1'b0;
  logic [7:0]  burstLen = '0;
  logic [7:0]  inByte = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] outWord;
  logic        outValid;
  logic        outReady = 1'b1;
  logic        rearmReq;

  always #10 clk = ~clk;

  ir_rle_encoder #(.DUR_W(TB_DUR), .OQ_DEPTH(TB_Q)) i_ir_rle_encoder (
    .clk(clk), .rstN(rstN), .burstGo(burstGo), .burstLen(burstLen),
    .inByte(inByte), .inValid(inValid), .inReady(inReady),
    .outWord(outWord), .outValid(outValid), .outReady(outReady),
    .rearmReq(rearmReq)
  );

  int errs = 0;
  int checks = 0;

  logic [31:0] expW [0:4095];
  logic [31:0] gotW [0:4095];
  int expN = 0;
  int gotN = 0;
  longint mPulse = 0, mSpace = 0;
  bit mLast = 0;
  bit rearmSeen = 0;
  logic [7:0] bb [0:63];

  always @(negedge clk) begin
    if (rstN && outValid && outReady && gotN < 4096) begin
      gotW[gotN] = outWord;
      gotN++;
    end
    if (rstN && rearmReq) rearmSeen = 1;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic modelEmit(input bit lvl, input longint dur);
    longint d;
    d = (dur > DMAX) ? DMAX : dur;
    if (expN < 4096) begin
      expW[expN] = 32'(d) | (32'(lvl) << TB_DUR);
      expN++;
    end
  endtask

  task automatic modelByte(input logic [7:0] b);
    logic [7:0] v;
    v = ~b;
    for (int k = 0; k < 8; k++) begin
      if (v[k]) begin
        if (!mLast) begin modelEmit(0, mSpace); mSpace = 0; end
        mPulse += TB_BIT;
      end else begin
        if (mLast) begin modelEmit(1, mPulse); mPulse = 0; end
        mSpace += TB_BIT;
      end
      mLast = v[k];
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; burstGo = 0; inValid = 0; outReady = 1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expN = 0; gotN = 0; mPulse = 0; mSpace = 0; mLast = 0; rearmSeen = 0;
    @(negedge clk);
  endtask

  // Offers up to 'offer' bytes from bb[]; returns how many were accepted.
  task automatic sendBurst(input int len, input int offer, output int taken);
    taken = 0;
    rearmSeen = 0;
    burstLen = 8'(len); burstGo = 1'b1;
    @(negedge clk);
    burstGo = 1'b0;
    for (int i = 0; i < offer; i++) begin
      int w;
      inByte = bb[i]; inValid = 1'b1; w = 0;
      while (!inReady && w < 20) begin @(negedge clk); w++; end
      if (!inReady) break;
      @(negedge clk);
      modelByte(bb[i]);
      taken++;
    end
    inValid = 1'b0;
    repeat (12) @(negedge clk);
    chk(rearmSeen == (mSpace > TB_LIMIT), "R9 rearm at burst end", rearmSeen, mSpace > TB_LIMIT);
  endtask

  task automatic compareAll(input string tag);
    chk(gotN == expN, {tag, " word count"}, gotN, expN);
    for (int i = 0; i < expN && i < gotN; i++)
      chk(gotW[i] === expW[i], tag, gotW[i], expW[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int t;
    doReset();
    // R1 reset state
    chk(outValid == 0, "R1 outValid after reset", outValid, 0);
    chk(inReady == 0, "R1 inReady after reset", inReady, 0);
    chk(rearmReq == 0, "R1 rearmReq after reset", rearmReq, 0);

    // R3/R5/R2: 0xFE -> inverted 0x01: pulse on bit 0, then space
    bb[0] = 8'hFE;
    sendBurst(1, 1, t);
    chk(gotN >= 2, "R5 words from 0xFE", gotN, 2);
    chk(gotW[0] == 32'h000, "R5 initial space of zero", gotW[0], 32'h000);
    chk(gotW[1] == 32'h434, "R3 lsb-first pulse of one bit", gotW[1], 32'h434);

    // R7: 24 pulse bits = 1248 us saturates to 1023
    doReset();
    bb[0] = 8'h00; bb[1] = 8'h00; bb[2] = 8'h00; bb[3] = 8'hFF;
    sendBurst(4, 4, t);
    chk(gotW[1] == 32'h7FF, "R7 saturated pulse word", gotW[1], 32'h7FF);
    compareAll("R7 saturation sequence");

    // R2/R3/R4/R5/R6: all single-byte values, state carried across bursts
    doReset();
    for (int v = 0; v < 256; v++) begin
      bb[0] = 8'(v);
      sendBurst(1, 1, t);
    end
    compareAll("R4 R6 single-byte sweep");

    // R4: multi-byte bursts of varying length
    doReset();
    for (int n = 1; n <= 6; n++) begin
      for (int i = 0; i < n; i++) bb[i] = 8'((n * 37 + i * 91) ^ 8'h3C);
      sendBurst(n, n, t);
      chk(t == n, "R8 full burst taken", t, n);
    end
    compareAll("R4 multi-byte bursts");

    // R8: cap at 32, and zero-length burst
    doReset();
    for (int i = 0; i < 40; i++) bb[i] = 8'(8'h33 + i);
    sendBurst(40, 40, t);
    chk(t == 32, "R8 burst capped at 32", t, 32);
    sendBurst(0, 1, t);
    chk(t == 0, "R8 zero-length burst takes nothing", t, 0);
    compareAll("R8 capped burst words");

    // R9: long silence: eight bursts of 32 space bytes
    doReset();
    for (int i = 0; i < 32; i++) bb[i] = 8'hFF;
    for (int k = 1; k <= 8; k++) sendBurst(32, 32, t);
    chk(rearmSeen == 1, "R9 rearm after 106496 us space", rearmSeen, 1);
    bb[0] = 8'h00;
    sendBurst(1, 1, t);
    chk(gotN >= 1 && gotW[0] == 32'h3FF, "R7 saturated space word", gotW[0], 32'h3FF);
    compareAll("R9 silence sequence");

    // R10/R11: queue full, words dropped, no stall
    doReset();
    outReady = 1'b0;
    bb[0] = 8'h55;
    sendBurst(1, 1, t);
    chk(t == 1, "R10 first byte taken while queue fills", t, 1);
    sendBurst(1, 1, t);
    chk(t == 1, "R10 no stall with full queue", t, 1);
    chk(outValid == 1, "R11 word held while not ready", outValid, 1);
    if (expN > TB_Q) expN = TB_Q;
    outReady = 1'b1;
    repeat (10) @(negedge clk);
    compareAll("R10 R11 surviving words in order");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule